// File: doc/BRIEF.md
# Cascaded Start Synchronizer

This block lets several identical line-interface devices, wired in cascade, begin operation on the same clock. Each device shares one open-drain ready line with its neighbours. A device keeps pulling that line low until its cascade-enable bit is set and a JK symbol pair has been reported by the symbol decoder. Once both conditions hold, it stops pulling. External logic raises a common cascade-start signal after every device has let go of the line. Each device then sees that start through its own synchronizer and produces a single-cycle start pulse.

The open-drain pin is modelled as a pull-low enable output. The level actually present on the shared line is returned as a separate input. A small mode register holds the stop/run bit and the cascade-enable bit. After reset, a busy window covers the settling time of the device's internal logic. JK reports and start edges that arrive inside this window are discarded.

Top module: `casc_start_sync`

## Requirements
- R1: Asserting rst_n low immediately clears mode_q to all zeros, which puts bit 0 in stop mode. It also sets ready_pull_lo to 1 and start_pulse to 0. All of this happens without waiting for a clock edge.
- R2: After rst_n is released, busy is 1 for between BUSY_CYC and BUSY_CYC+3 clock cycles. It then stays 0.
- R3: A jk_pulse seen while busy is 1 has no effect, so ready_pull_lo stays 1. The same pulse given after busy has dropped releases the line.
- R4: A cycle with mode_wr=1 loads mode_wdata into mode_q at that clock edge. Bit 0 is run (1) or stop (0), and bit 1 is cascade enable.
- R5: ready_pull_lo goes to 0 only on the edge after cascade enable has been seen at 1 and a jk_pulse is sampled. A jk_pulse sampled while cascade enable is 0 is not remembered.
- R6: One cycle after cascade enable is cleared, ready_pull_lo returns to 1 and the received JK is forgotten.
- R7: A rising edge on cstart_in, while the line is released and line_lvl is high, gives a start_pulse exactly one cycle wide. The pulse appears in the third cycle after the edge is sampled, because of a two-flop synchronizer plus an edge detector.
- R8: If cstart_in is already high when the line is released, no start pulse is produced. A fresh rising edge is needed.
- R9: A cstart_in rising edge is ignored while the synchronized line_lvl is low.
- R10: Once a start pulse has fired, further cstart_in edges give no pulse until cascade enable has been cleared and set again. The line stays released during this time.
- R11: If the clearing of cascade enable and a synchronized start edge take effect on the same edge, the clear wins. No pulse is produced and the line is pulled low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | MODE_W | Mode register write data |
| jk_pulse | input | 1 | One-cycle report that a JK symbol pair arrived |
| cstart_in | input | 1 | Asynchronous shared cascade-start input |
| line_lvl | input | 1 | Sensed level of the shared ready line |
| ready_pull_lo | output | 1 | 1 = pull the shared ready line low |
| start_pulse | output | 1 | One-cycle synchronized start |
| busy | output | 1 | Post-reset settling window |
| mode_q | output | MODE_W | Current mode register contents |

## Verification
Two functions can meet on one edge: withdrawing cascade enable, and accepting a synchronized start edge. The bench provokes this by raising cstart_in one cycle before it writes the clear. The synchronizer then delivers the edge on exactly the clock where the cleared mode bit reaches the sequencer. The bench judges the outcome as correct only if start_pulse stays low on that cycle and the next one, and ready_pull_lo returns to 1.

// File: rtl/casc_start_pkg.sv
package casc_start_pkg;
  typedef enum logic [1:0] {
    CS_IDLE    = 2'd0,
    CS_WAIT_JK = 2'd1,
    CS_READY   = 2'd2,
    CS_STARTED = 2'd3
  } cs_state_e;
endpackage

// File: rtl/casc_rst_sync.sv
module casc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_s = stage_q[1];
endmodule

// File: rtl/casc_bit_sync.sv
module casc_bit_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n_s,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[b];
        stable_q <= meta_q;
      end
    end
    assign sync_out[b] = stable_q;
  end
endmodule

// File: rtl/casc_busy_timer.sv
module casc_busy_timer #(
  parameter int BUSY_CYC = 96
) (
  input  logic clk,
  input  logic rst_n_s,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = cnt_en;

  // R2
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |=> !busy);
endmodule

// File: rtl/casc_mode_reg.sv
module casc_mode_reg #(
  parameter int MODE_W   = 4,
  parameter int CASC_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n_s,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              casc_en
);
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= '0;
    else if (wr)  mode_q <= wdata;
  end

  assign casc_en = mode_q[CASC_BIT];

  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr |=> mode_q == $past(wdata));
endmodule

// File: rtl/casc_start_fsm.sv
module casc_start_fsm
  import casc_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n_s,
  input  logic casc_en,
  input  logic busy,
  input  logic jk_pulse,
  input  logic start_s,
  input  logic line_s,
  output logic ready_pull_lo,
  output logic start_pulse
);
  cs_state_e st_q, st_d;
  logic      prev_q;
  logic      start_rise;
  logic      fire_d;
  logic      pulse_q;

  assign start_rise = start_s & ~prev_q;

  always_comb begin
    st_d   = st_q;
    fire_d = 1'b0;
    if (!casc_en) begin
      st_d = CS_IDLE;
    end else begin
      unique case (st_q)
        CS_IDLE:    st_d = CS_WAIT_JK;
        CS_WAIT_JK: if (jk_pulse && !busy) st_d = CS_READY;
        CS_READY: begin
          if (!busy && start_rise && line_s) begin
            st_d   = CS_STARTED;
            fire_d = 1'b1;
          end
        end
        CS_STARTED: st_d = CS_STARTED;
        default:    st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= CS_IDLE;
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      prev_q  <= start_s;
      pulse_q <= fire_d;
    end
  end

  assign ready_pull_lo = !((st_q == CS_READY) || (st_q == CS_STARTED));
  assign start_pulse   = pulse_q;

  // R5
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(ready_pull_lo) |-> ($past(casc_en) && $past(jk_pulse)));

  // R6
  casc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(casc_en) |=> ready_pull_lo);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> ready_pull_lo);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_pulse |=> !start_pulse);
endmodule

// File: rtl/casc_start_sync.sv
module casc_start_sync #(
  parameter int MODE_W   = 4,
  parameter int CASC_BIT = 1,
  parameter int BUSY_CYC = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              jk_pulse,
  input  logic              cstart_in,
  input  logic              line_lvl,
  output logic              ready_pull_lo,
  output logic              start_pulse,
  output logic              busy,
  output logic [MODE_W-1:0] mode_q
);
  localparam int NSYNC = 2;

  logic             rst_n_s;
  logic             casc_en;
  logic [NSYNC-1:0] sync_v;

  casc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  casc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .busy    (busy)
  );

  casc_mode_reg #(.MODE_W(MODE_W), .CASC_BIT(CASC_BIT)) u_mode (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .wr      (mode_wr),
    .wdata   (mode_wdata),
    .mode_q  (mode_q),
    .casc_en (casc_en)
  );

  casc_bit_sync #(.WIDTH(NSYNC)) u_sync (
    .clk      (clk),
    .rst_n_s  (rst_n_s),
    .async_in ({line_lvl, cstart_in}),
    .sync_out (sync_v)
  );

  casc_start_fsm u_fsm (
    .clk           (clk),
    .rst_n_s       (rst_n_s),
    .casc_en       (casc_en),
    .busy          (busy),
    .jk_pulse      (jk_pulse),
    .start_s       (sync_v[0]),
    .line_s        (sync_v[1]),
    .ready_pull_lo (ready_pull_lo),
    .start_pulse   (start_pulse)
  );
endmodule

// File: tb/casc_start_sync_tb.sv
module casc_start_sync_tb_top;
  localparam int CLK_P  = 10;
  localparam int MW     = 4;
  localparam int BCYC   = 96;
  localparam int NV     = 31;

  // vector: [7]wr [6:5]wdata [4]jk [3]cstart [2]line [1]exp pull_lo [0]exp pulse
  localparam logic [7:0] VEC [NV] = '{
    8'b1_11_0_0_0_1_0, 8'b0_00_0_0_0_1_0, 8'b0_00_1_0_0_0_0, 8'b0_00_0_1_1_0_0,
    8'b0_00_0_1_1_0_0, 8'b0_00_0_1_1_0_1, 8'b0_00_0_1_1_0_0, 8'b0_00_0_0_1_0_0,
    8'b0_00_0_0_1_0_0, 8'b0_00_0_0_1_0_0, 8'b0_00_0_1_1_0_0, 8'b0_00_0_1_1_0_0,
    8'b0_00_0_1_1_0_0, 8'b1_01_0_0_0_0_0, 8'b0_00_0_0_0_1_0, 8'b0_00_1_0_0_1_0,
    8'b1_11_0_0_0_1_0, 8'b0_00_0_0_0_1_0, 8'b0_00_0_1_1_1_0, 8'b0_00_0_1_1_1_0,
    8'b0_00_0_1_1_1_0, 8'b0_00_1_1_1_0_0, 8'b0_00_0_1_1_0_0, 8'b0_00_0_0_1_0_0,
    8'b0_00_0_0_1_0_0, 8'b0_00_0_0_1_0_0, 8'b0_00_0_1_0_0_0, 8'b0_00_0_1_0_0_0,
    8'b0_00_0_1_0_0_0, 8'b0_00_0_1_1_0_0, 8'b0_00_0_1_1_0_0
  };
  // rows: 0-6 arm and start (R4 R5 R7), 7-12 edges after start (R10),
  // 13-17 clear and JK while disabled (R6 R5), 18-22 start high early (R8),
  // 23-30 edge with line low (R9)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [MW-1:0] mode_wdata = '0;
  logic          jk_pulse = 1'b0;
  logic          cstart_in = 1'b0;
  logic          line_lvl = 1'b0;
  logic          ready_pull_lo, start_pulse, busy;
  logic [MW-1:0] mode_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  casc_start_sync #(.MODE_W(MW), .CASC_BIT(1), .BUSY_CYC(BCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .jk_pulse(jk_pulse), .cstart_in(cstart_in), .line_lvl(line_lvl),
    .ready_pull_lo(ready_pull_lo), .start_pulse(start_pulse), .busy(busy),
    .mode_q(mode_q)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_idle_busy();
    int n = 0;
    while (busy && n < BCYC + 10) begin tick(); n++; end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int hi_cnt;
    #1;
    // R1 reset state while held
    chk("R1 mode_q", int'(mode_q), 0);
    chk("R1 pull_lo", int'(ready_pull_lo), 1);
    chk("R1 pulse", int'(start_pulse), 0);
    repeat (3) tick();
    rst_n = 1'b1;
    // R2 busy window length
    hi_cnt = 0;
    while (busy && hi_cnt < BCYC + 10) begin tick(); hi_cnt++; end
    chk("R2 busy window ok", int'(hi_cnt >= BCYC && hi_cnt <= BCYC + 3), 1);
    repeat (4) tick();
    chk("R2 busy stays low", int'(busy), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      mode_wr    = VEC[i][7];
      mode_wdata = {2'b00, VEC[i][6:5]};
      jk_pulse   = VEC[i][4];
      cstart_in  = VEC[i][3];
      line_lvl   = VEC[i][2];
      tick();
      chk($sformatf("R5/R7 row %0d pull_lo", i), int'(ready_pull_lo), int'(VEC[i][1]));
      chk($sformatf("R7/R10 row %0d pulse", i), int'(start_pulse), int'(VEC[i][0]));
      if (i == 0) chk("R4 mode_q after write", int'(mode_q), 3);
    end
    mode_wr = 1'b0; jk_pulse = 1'b0;

    // R11 clear and start edge meeting on one edge
    cstart_in = 1'b0;
    repeat (3) tick();
    cstart_in = 1'b1; line_lvl = 1'b1;
    tick();
    mode_wr = 1'b1; mode_wdata = 4'b0001;
    tick();
    mode_wr = 1'b0;
    tick();
    chk("R11 no pulse on collision", int'(start_pulse), 0);
    chk("R11 line pulled again", int'(ready_pull_lo), 1);
    tick();
    chk("R11 no late pulse", int'(start_pulse), 0);

    // R3 JK during busy, then after busy
    rst_n = 1'b0; cstart_in = 1'b0; line_lvl = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    mode_wr = 1'b1; mode_wdata = 4'b0011;
    tick();
    mode_wr = 1'b0;
    chk("R4 mode_q during busy", int'(mode_q), 3);
    tick();
    jk_pulse = 1'b1;
    tick();
    jk_pulse = 1'b0;
    chk("R3 still busy", int'(busy), 1);
    tick();
    chk("R3 JK ignored while busy", int'(ready_pull_lo), 1);
    wait_idle_busy();
    tick();
    chk("R3 still pulled after busy", int'(ready_pull_lo), 1);
    jk_pulse = 1'b1;
    tick();
    jk_pulse = 1'b0;
    chk("R3 JK after busy releases", int'(ready_pull_lo), 0);

    // R1 asynchronous reset from released state
    rst_n = 1'b0;
    #1;
    chk("R1 async pull_lo", int'(ready_pull_lo), 1);
    chk("R1 async mode_q", int'(mode_q), 0);
    chk("R1 async busy", int'(busy), 1);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    finish_run();
  end
endmodule